// File: doc/BRIEF.md
# Watchdog with delayed reset

This block supervises software with a free-running counter clocked from a reference clock that is separate from the bus clock. Software must refresh the counter before it reaches a programmable compare value. A refresh strobe with its valid flag low counts as a fault, and so does a counter timeout. Either fault leads to a reset. When the interrupt option is on, the block first raises an interrupt request and holds the reset back for a fixed window of bus clocks. This gives a service routine time to record the state of the failing code before the reset lands.

A second, independent path lives entirely in the reference-clock domain. If the counter times out twice with no clearing event in between, this path pulses the reset output itself. It therefore still works when the bus clock has died. Mode inputs for debug halt, wait and stop switch the watchdog off unless the matching enable bit keeps it alive. In stop mode the block can reset but never interrupts. Overflow events travel to the bus domain as toggles through a two-flop synchronizer. Clear requests travel to the reference domain the same way.

Top module: `wdog_delayed_reset`

## Requirements
- R1: After `rst_n` is released, both `wdog_irq` and `wdog_rst` are low.
- R2: While the watchdog is active, a bus cycle with `refresh_stb` high and `refresh_ok` low is a fault that starts the reset sequence.
- R3: With `cfg_irq_en` high and not in stop mode, a fault raises `wdog_irq` in the next bus cycle. The request stays high for exactly DELAY_CYCLES (default 128) bus cycles. It then drops in the same cycle that `wdog_rst` rises, and `wdog_rst` stays high for one bus cycle.
- R4: With `cfg_irq_en` low, a fault raises `wdog_rst` in the next bus cycle for a single cycle, and `wdog_irq` stays low.
- R5: While active, the counter advances once per `ref_clk` edge. When it equals `cfg_timeout` it restarts from zero and signals an overflow, which is a fault. After a valid refresh, this fault reaches the outputs no sooner than `cfg_timeout`+1 and no later than `cfg_timeout`+9 reference periods.
- R6: A valid refresh (`refresh_stb` and `refresh_ok` both high) clears the counter and the first-overflow flag. Refreshing more often than every `cfg_timeout`+1 reference periods never produces a fault.
- R7: Faults that arrive during the interrupt window or the reset cycle are ignored. The window is not restarted and the reset pulses once.
- R8: With `mode_wait` (or `mode_dbg`) high and `cfg_wait_run` (or `cfg_dbg_run`) low, the watchdog is inactive: the counter holds and invalid refreshes are ignored. Setting the enable bit lets counting resume.
- R9: With `mode_stop` and `cfg_stop_run` high, a fault gives the immediate one-cycle reset of R4 even when `cfg_irq_en` is high, and `wdog_irq` never rises.
- R10: When `cfg_ref_is_bus` is low, two overflows with no clear in between pulse `wdog_rst` for one `ref_clk` period, even while `bus_clk` is stopped.
- R11: When `cfg_ref_is_bus` is high, the double-overflow path never pulses `wdog_rst`.
- R12: With `cfg_enable` low, no fault is recognised and the counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock; drives the fault logic and the interrupt window |
| ref_clk | input | 1 | Reference clock for the watchdog counter |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| cfg_enable | input | 1 | Master enable |
| cfg_irq_en | input | 1 | 1: interrupt first, then reset after the window; 0: reset at once |
| cfg_dbg_run | input | 1 | Keep running during debug halt |
| cfg_wait_run | input | 1 | Keep running during wait mode |
| cfg_stop_run | input | 1 | Keep running during stop mode |
| cfg_ref_is_bus | input | 1 | 1: counter clock source is the bus clock, which disables the double-overflow path |
| cfg_timeout | input | CNT_W | Compare value for the counter |
| refresh_stb | input | 1 | Refresh attempt strobe (bus domain) |
| refresh_ok | input | 1 | Refresh attempt is valid when high |
| mode_dbg | input | 1 | Debug-halt mode indicator |
| mode_wait | input | 1 | Wait mode indicator |
| mode_stop | input | 1 | Stop mode indicator |
| wdog_irq | output | 1 | Interrupt request, high for the whole delay window |
| wdog_rst | output | 1 | Reset request pulse |

## Verification
A wrong window count shows up within one bus cycle of the expected fall of `wdog_irq`, because a reference model in the bench predicts both outputs on every bus cycle. A stuck or uncleared counter, or a lost crossing toggle, shows up as a fault arriving outside the R5 bound, or arriving while refreshes are still being made. A first-overflow flag that is not cleared, or a wrong backup enable, shows up within about two timeout periods as a missing or extra reset pulse while the bus clock is stopped.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    WD_IDLE   = 2'd0,
    WD_WINDOW = 2'd1,
    WD_FIRE   = 2'd2
  } wd_state_t;

endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/wdog_sync.sv
module wdog_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], d};
  end

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/wdog_ref_counter.sv
module wdog_ref_counter #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             run_async,
  input  logic             bak_en_async,
  input  logic             clr_tgl_async,
  input  logic [CNT_W-1:0] timeout,
  output logic             ovf_tgl,
  output logic             bak_rst
);

  localparam int XW = 3;

  logic [XW-1:0]    xin, xout;
  logic             run_s, bak_en_s, clr_s;
  logic             clr_seen_q;
  logic             clr_evt;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             first_q, first_d;
  logic             tgl_q, tgl_d;
  logic             bak_q, bak_d;
  logic             hit;
  logic             cnt_en;

  assign xin = {run_async, bak_en_async, clr_tgl_async};

  wdog_sync #(.WIDTH(XW), .STAGES(SYNC_STAGES)) u_xsync (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .d     (xin),
    .q     (xout)
  );

  assign {run_s, bak_en_s, clr_s} = xout;
  assign clr_evt = clr_s ^ clr_seen_q;
  assign hit     = run_s && (cnt_q == timeout);
  assign cnt_en  = clr_evt || run_s;

  always_comb begin
    cnt_d   = cnt_q;
    first_d = first_q;
    tgl_d   = tgl_q;
    bak_d   = 1'b0;
    if (clr_evt) begin
      cnt_d   = '0;
      first_d = 1'b0;
    end else if (run_s) begin
      if (hit) begin
        cnt_d = '0;
        tgl_d = ~tgl_q;
        if (first_q && bak_en_s) begin
          bak_d   = 1'b1;
          first_d = 1'b0;
        end else begin
          first_d = 1'b1;
        end
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      first_q    <= 1'b0;
      tgl_q      <= 1'b0;
      bak_q      <= 1'b0;
      clr_seen_q <= 1'b0;
    end else begin
      if (cnt_en) begin
        cnt_q   <= cnt_d;
        first_q <= first_d;
      end
      tgl_q      <= tgl_d;
      bak_q      <= bak_d;
      clr_seen_q <= clr_s;
    end
  end

  assign ovf_tgl = tgl_q;
  assign bak_rst = bak_q;

  AST_BAK_ONE_PULSE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    bak_q |=> !bak_q) else $error("backup pulse too long"); // R10

  AST_BAK_AFTER_FIRST: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(bak_q) |-> $past(first_q)) else $error("backup without first overflow"); // R10

  AST_CLR_ZEROES: assert property (@(posedge ref_clk) disable iff (!rst_n)
    clr_evt |=> (cnt_q == '0 && !first_q)) else $error("clear did not restart counter"); // R6

endmodule

// File: rtl/wdog_delay_ctrl.sv
module wdog_delay_ctrl
  import wdog_pkg::*;
#(
  parameter int DELAY_CYCLES = 128,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic irq_en,
  input  logic stop_mode,
  input  logic bad_refresh,
  input  logic good_refresh,
  input  logic ovf_tgl_async,
  output logic irq_o,
  output logic rst_o,
  output logic clr_tgl
);

  localparam int DLY_W = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(DELAY_CYCLES - 1);

  wd_state_t        state_q, state_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic             dly_en;
  logic             ovf_s, ovf_seen_q, ovf_evt;
  logic             trig;
  logic             enter_fire;
  logic             clr_q, clr_d;

  wdog_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ovf_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ovf_tgl_async),
    .q     (ovf_s)
  );

  assign ovf_evt = ovf_s ^ ovf_seen_q;
  assign trig    = active && (bad_refresh || ovf_evt);

  always_comb begin
    state_d = state_q;
    dly_d   = dly_q;
    case (state_q)
      WD_IDLE: begin
        if (trig) begin
          dly_d   = '0;
          state_d = (irq_en && !stop_mode) ? WD_WINDOW : WD_FIRE;
        end
      end
      WD_WINDOW: begin
        if (dly_q == DLY_LAST) begin
          state_d = WD_FIRE;
          dly_d   = '0;
        end else begin
          dly_d = dly_q + DLY_W'(1);
        end
      end
      WD_FIRE: state_d = WD_IDLE;
      default: state_d = WD_IDLE;
    endcase
  end

  assign dly_en     = (state_q == WD_WINDOW) || (state_d != state_q);
  assign enter_fire = (state_d == WD_FIRE) && (state_q != WD_FIRE);
  assign clr_d      = clr_q ^ (good_refresh || enter_fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= WD_IDLE;
      dly_q      <= '0;
      ovf_seen_q <= 1'b0;
      clr_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      if (dly_en) dly_q <= dly_d;
      ovf_seen_q <= ovf_s;
      clr_q      <= clr_d;
    end
  end

  assign irq_o   = (state_q == WD_WINDOW);
  assign rst_o   = (state_q == WD_FIRE);
  assign clr_tgl = clr_q;

  AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_o |=> !rst_o) else $error("reset longer than one cycle"); // R4

  AST_IRQ_ENDS_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> rst_o) else $error("window ended without reset"); // R3

  AST_WINDOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> (irq_o || rst_o)) else $error("window aborted"); // R7

  AST_NO_IRQ_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> !$past(stop_mode)) else $error("interrupt in stop mode"); // R9

  AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(irq_en)) else $error("interrupt while disabled"); // R4

  AST_DIRECT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_IDLE && trig && !irq_en) |=> rst_o) else $error("reset not immediate"); // R4

endmodule

// File: rtl/wdog_delayed_reset.sv
module wdog_delayed_reset #(
  parameter int CNT_W        = 16,
  parameter int DELAY_CYCLES = 128,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             bus_clk,
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_irq_en,
  input  logic             cfg_dbg_run,
  input  logic             cfg_wait_run,
  input  logic             cfg_stop_run,
  input  logic             cfg_ref_is_bus,
  input  logic [CNT_W-1:0] cfg_timeout,
  input  logic             refresh_stb,
  input  logic             refresh_ok,
  input  logic             mode_dbg,
  input  logic             mode_wait,
  input  logic             mode_stop,
  output logic             wdog_irq,
  output logic             wdog_rst
);

  logic bus_rst_n, ref_rst_n;
  logic active;
  logic run_q;
  logic ovf_tgl, clr_tgl;
  logic fire, bak;

  wdog_rst_sync #(.STAGES(SYNC_STAGES)) u_bus_rs (
    .clk(bus_clk), .arst_n(rst_n), .srst_n(bus_rst_n)
  );

  wdog_rst_sync #(.STAGES(SYNC_STAGES)) u_ref_rs (
    .clk(ref_clk), .arst_n(rst_n), .srst_n(ref_rst_n)
  );

  assign active = cfg_enable
               && (!mode_dbg  || cfg_dbg_run)
               && (!mode_wait || cfg_wait_run)
               && (!mode_stop || cfg_stop_run);

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) run_q <= 1'b0;
    else            run_q <= active;
  end

  wdog_delay_ctrl #(
    .DELAY_CYCLES (DELAY_CYCLES),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_ctrl (
    .clk           (bus_clk),
    .rst_n         (bus_rst_n),
    .active        (active),
    .irq_en        (cfg_irq_en),
    .stop_mode     (mode_stop),
    .bad_refresh   (refresh_stb && !refresh_ok),
    .good_refresh  (refresh_stb && refresh_ok),
    .ovf_tgl_async (ovf_tgl),
    .irq_o         (wdog_irq),
    .rst_o         (fire),
    .clr_tgl       (clr_tgl)
  );

  wdog_ref_counter #(
    .CNT_W       (CNT_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_cnt (
    .ref_clk       (ref_clk),
    .rst_n         (ref_rst_n),
    .run_async     (run_q),
    .bak_en_async  (!cfg_ref_is_bus),
    .clr_tgl_async (clr_tgl),
    .timeout       (cfg_timeout),
    .ovf_tgl       (ovf_tgl),
    .bak_rst       (bak)
  );

  assign wdog_rst = fire || bak;

  AST_BAK_TIED_OFF: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    ($past(cfg_ref_is_bus, 3) && $past(cfg_ref_is_bus, 2) && $past(cfg_ref_is_bus)) |-> !bak)
    else $error("backup reset with bus-clock source"); // R11

endmodule

// File: tb/test_wdog_delayed_reset.sv
module test_wdog_delayed_reset;

  localparam int CNT_W = 16;
  localparam int DLY   = 128;

  logic bus_raw = 1'b0;
  logic bus_gate = 1'b1;
  logic bus_clk;
  logic ref_clk = 1'b0;
  logic rst_n;
  logic cfg_enable, cfg_irq_en, cfg_dbg_run, cfg_wait_run, cfg_stop_run, cfg_ref_is_bus;
  logic [CNT_W-1:0] cfg_timeout;
  logic refresh_stb, refresh_ok, mode_dbg, mode_wait, mode_stop;
  logic wdog_irq, wdog_rst;

  assign bus_clk = bus_raw & bus_gate;
  always #2 bus_raw = ~bus_raw;
  initial begin #1; forever #8 ref_clk = ~ref_clk; end

  wdog_delayed_reset #(.CNT_W(CNT_W), .DELAY_CYCLES(DLY)) i_wdog_delayed_reset (
    .bus_clk, .ref_clk, .rst_n, .cfg_enable, .cfg_irq_en, .cfg_dbg_run,
    .cfg_wait_run, .cfg_stop_run, .cfg_ref_is_bus, .cfg_timeout,
    .refresh_stb, .refresh_ok, .mode_dbg, .mode_wait, .mode_stop,
    .wdog_irq, .wdog_rst
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state: 0 idle, 1 window, 2 reset cycle
  int m_state = 0;
  int m_cnt = 0;
  bit allow_ovf = 0;
  int irq_cyc = 0;
  int rst_cyc = 0;
  int bak_cnt = 0;
  bit s_act, s_bad, s_irqen, s_stop;

  always @(posedge bus_clk) begin
    s_act   = cfg_enable && (!mode_dbg || cfg_dbg_run) && (!mode_wait || cfg_wait_run)
              && (!mode_stop || cfg_stop_run);
    s_bad   = refresh_stb && !refresh_ok;
    s_irqen = cfg_irq_en;
    s_stop  = mode_stop;
  end

  always @(negedge bus_clk) begin
    if (!rst_n) begin
      m_state = 0;
      m_cnt   = 0;
    end else begin
      if (m_state == 0) begin
        if (s_act && s_bad) begin
          m_state = (s_irqen && !s_stop) ? 1 : 2;
          m_cnt   = 0;
        end
      end else if (m_state == 1) begin
        if (m_cnt == DLY - 1) m_state = 2;
        else m_cnt++;
      end else begin
        m_state = 0;
      end
      if (m_state == 0 && allow_ovf && (wdog_irq || wdog_rst)) begin
        m_state = wdog_irq ? 1 : 2;
        m_cnt   = 0;
      end
      checks++;
      if (wdog_irq !== (m_state == 1) || wdog_rst !== (m_state == 2)) begin
        errors++;
        $display("FAIL %s per-cycle: act irq=%0b rst=%0b exp irq=%0b rst=%0b",
                 cur_req, wdog_irq, wdog_rst, m_state == 1, m_state == 2);
      end
      if (wdog_irq) irq_cyc++;
      if (wdog_rst) rst_cyc++;
    end
  end

  always @(posedge wdog_rst) if (!bus_gate) bak_cnt++;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge bus_raw) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: act=hung exp=finished");
      summary();
      $finish;
    end
  end

  task automatic check_eq(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_rng(string req, int act, int lo, int hi, string what);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s %s: act=%0d exp=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic defaults();
    cfg_enable = 1; cfg_irq_en = 1; cfg_dbg_run = 0; cfg_wait_run = 0;
    cfg_stop_run = 0; cfg_ref_is_bus = 0; cfg_timeout = 16'd1000;
    refresh_stb = 0; refresh_ok = 0; mode_dbg = 0; mode_wait = 0; mode_stop = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    allow_ovf = 0;
    @(negedge bus_raw) bus_gate = 1;
    repeat (4) @(negedge bus_clk);
    rst_n = 1;
    repeat (6) @(negedge bus_clk);
    irq_cyc = 0;
    rst_cyc = 0;
    bak_cnt = 0;
  endtask

  task automatic refresh(bit ok);
    @(negedge bus_clk);
    refresh_stb = 1;
    refresh_ok  = ok;
    @(negedge bus_clk);
    refresh_stb = 0;
    refresh_ok  = 0;
  endtask

  task automatic wait_fault(int limit, output int n);
    n = 0;
    while (n < limit && !(wdog_irq || wdog_rst)) begin
      @(negedge bus_clk);
      n++;
    end
    @(negedge bus_clk);
    allow_ovf = 0;
  endtask

  initial begin
    int n;
    rst_n = 0;
    defaults();
    do_reset();

    cur_req = "R1";
    check_eq("R1", wdog_irq, 0, "irq after reset");
    check_eq("R1", wdog_rst, 0, "rst after reset");

    // R2, R3, R7: invalid refresh opens the window; a second fault inside is ignored
    cur_req = "R3";
    refresh(0);
    repeat (40) @(negedge bus_clk);
    cur_req = "R7";
    refresh(0);
    repeat (120) @(negedge bus_clk);
    check_eq("R2", irq_cyc > 0, 1, "invalid refresh caused interrupt");
    check_eq("R3", irq_cyc, DLY, "interrupt window length");
    check_eq("R7", rst_cyc, 1, "single reset pulse");

    // R4: interrupt disabled gives immediate reset
    cur_req = "R4";
    defaults(); cfg_irq_en = 0;
    do_reset();
    refresh(0);
    repeat (10) @(negedge bus_clk);
    check_eq("R4", rst_cyc, 1, "immediate reset count");
    check_eq("R4", irq_cyc, 0, "no interrupt when disabled");

    // R5: counter timeout within bound
    cur_req = "R5";
    defaults(); cfg_timeout = 16'd60;
    do_reset();
    refresh(1);
    allow_ovf = 1;
    wait_fault(400, n);
    check_rng("R5", n, 4 * 61 - 4, 4 * 69, "timeout latency in bus cycles");
    repeat (140) @(negedge bus_clk);
    check_eq("R5", rst_cyc, 1, "reset after timeout window");

    // R6: regular refresh prevents any fault
    cur_req = "R6";
    defaults(); cfg_timeout = 16'd60;
    do_reset();
    for (int i = 0; i < 16; i++) begin
      refresh(1);
      repeat (118) @(negedge bus_clk);
    end
    check_eq("R6", irq_cyc + rst_cyc, 0, "no fault while refreshed");

    // R8: wait mode without its enable freezes everything
    cur_req = "R8";
    defaults(); cfg_timeout = 16'd60; mode_wait = 1;
    do_reset();
    refresh(1);
    repeat (600) @(negedge bus_clk);
    refresh(0);
    repeat (20) @(negedge bus_clk);
    check_eq("R8", irq_cyc + rst_cyc, 0, "inactive in wait mode");
    @(negedge bus_clk);
    cfg_wait_run = 1;
    allow_ovf = 1;
    wait_fault(400, n);
    check_eq("R8", n < 400, 1, "counting resumes with wait enable");
    repeat (140) @(negedge bus_clk);
    // debug mode kept alive by its enable bit
    defaults(); cfg_irq_en = 0; mode_dbg = 1; cfg_dbg_run = 1;
    do_reset();
    refresh(0);
    repeat (5) @(negedge bus_clk);
    check_eq("R8", rst_cyc, 1, "debug mode with enable resets");

    // R9: stop mode resets at once, never interrupts
    cur_req = "R9";
    defaults(); mode_stop = 1; cfg_stop_run = 1;
    do_reset();
    refresh(0);
    repeat (10) @(negedge bus_clk);
    check_eq("R9", rst_cyc, 1, "stop mode immediate reset");
    check_eq("R9", irq_cyc, 0, "no interrupt in stop mode");

    // R12: master enable off
    cur_req = "R12";
    defaults(); cfg_enable = 0; cfg_timeout = 16'd30;
    do_reset();
    refresh(0);
    repeat (600) @(negedge bus_clk);
    check_eq("R12", irq_cyc + rst_cyc, 0, "disabled watchdog silent");

    // R10: double overflow with bus clock stopped
    cur_req = "R10";
    defaults(); cfg_timeout = 16'd20;
    do_reset();
    refresh(1);
    @(negedge bus_raw) bus_gate = 0;
    repeat (60) @(posedge ref_clk);
    check_eq("R10", bak_cnt, 1, "backup reset pulses");

    // R11: backup path tied off for bus-clock source
    cur_req = "R11";
    defaults(); cfg_timeout = 16'd20; cfg_ref_is_bus = 1;
    do_reset();
    refresh(1);
    @(negedge bus_raw) bus_gate = 0;
    repeat (60) @(posedge ref_clk);
    check_eq("R11", bak_cnt, 0, "no backup reset");
    do_reset();
    check_eq("R1", wdog_rst, 0, "clean after final reset");

    done = 1;
    summary();
    $finish;
  end

endmodule